// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block models a small serial EEPROM as it looks from its pins. It holds `2**ADDR_W` words of `WORD_W` bits each, in a register array. The default is 6 address bits and 64 words; setting `ADDR_W` to 8 gives 256 words. A host raises chip select and clocks in a command one bit per rising edge of the serial clock. A command is a start bit of 1, then a two-bit opcode, then the address, then data bits for the commands that carry data. For a read, the device shifts the addressed word back out.

The serial pins are sampled by the system clock. The block detects a rising edge of the serial clock by comparing it with its value one system clock earlier. The host paces every transfer through the serial clock, so the serial interface has no valid/ready handshake. There is also no back-pressure: the device never stalls the host. Each bit is taken on the system clock edge where the serial clock is first seen high. The host must hold the serial clock high and low for at least two system clocks each.

The opcodes are: `10` read, `01` write, `11` erase, and `00` extended. In an extended command, the two most significant address bits pick the function: `11` unlocks programming, `10` erases every word, `01` writes one word to every location, and `00` locks programming. The lower address bits of an extended command are ignored. A program command is applied one system clock after its final bit is received.

Top module: `uwire_eeprom`

## Requirements
- R1: After reset, data out is 0, every word reads 0xFFFF, and programming is locked. A write issued before any unlock leaves the word unchanged.
- R2: A read (opcode `10`) drives a single 0 on data out once the last address bit is taken. The next 16 rising serial-clock edges each present the next bit of the word, MSB first.
- R3: While unlocked, a write (opcode `01`) stores the 16 data bits that follow the address, sent MSB first, into the addressed word.
- R4: While unlocked, an erase (opcode `11`) sets every bit of the addressed word to 1.
- R5: While unlocked, the extended command with top address bits `10` sets every word to 0xFFFF.
- R6: While unlocked, the extended command with top address bits `01` stores its 16 data bits into every word.
- R7: The extended command with top address bits `00` locks programming. After it, write, erase, erase-all and write-all leave the storage unchanged until the next unlock.
- R8: Dropping chip select abandons a partly received command without any effect. The decoder then ignores 0 bits until it sees a start bit of 1.
- R9: Data out is 0 in all of these cases: chip select is low, a command is still being shifted in, or a read has presented all 16 bits and a further serial-clock edge has arrived.
- R10: The unlock command (top address bits `11`) takes effect whatever values its lower address bits carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial command, address and data input |
| sdo_o | output | 1 | Serial read data output |

## Verification
Suppose the decoder's state or bit counter is wrong. Then the next read returns a word with every bit shifted by one position, or it loses its leading zero; either shows on data out within one command. Suppose the lock latch is wrong. Then it shows only when a program command that should be blocked (or allowed) is followed by a read-back, so every lock test pairs the command with a read. A stuck storage word appears at the very next read of that address. Abort bugs appear when a fragment is followed by a full command, and that command either misdecodes or writes a location it should not.

// File: rtl/uwire_pkg.sv
package uwire_pkg;
  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } uw_op_e;

  typedef enum logic [1:0] {
    EXT_LOCK   = 2'b00,
    EXT_FILL   = 2'b01,
    EXT_CLEAR  = 2'b10,
    EXT_UNLOCK = 2'b11
  } uw_ext_e;

  typedef enum logic [2:0] {
    S_IDLE, S_OP, S_ADDR, S_DATA, S_READ, S_DONE
  } uw_state_e;
endpackage

// File: rtl/uwire_rx.sv
module uwire_rx
  import uwire_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic              fire_o,
  output logic [1:0]        op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] data_o,
  output logic              sdo_o
);
  localparam int CW = $clog2(WORD_W + 2);

  uw_state_e         st;
  logic              sclk_q;
  logic              sclk_rise;
  logic [CW-1:0]     cnt;
  logic [1:0]        op;
  logic [ADDR_W-1:0] addr_sr;
  logic [WORD_W-1:0] data_sr;
  logic [WORD_W:0]   rd_sr;
  logic [ADDR_W-1:0] addr_full;
  logic [WORD_W-1:0] data_full;
  logic              needs_data;
  logic              addr_last;
  logic              data_last;

  assign sclk_rise = sclk_i & ~sclk_q;
  assign addr_full = {addr_sr[ADDR_W-2:0], sdi_i};
  assign data_full = {data_sr[WORD_W-2:0], sdi_i};
  assign needs_data = (op == OP_WRITE) ||
                      ((op == OP_EXT) && (addr_full[ADDR_W-1 -: 2] == EXT_FILL));
  assign addr_last = (st == S_ADDR) && (cnt == CW'(ADDR_W - 1));
  assign data_last = (st == S_DATA) && (cnt == CW'(WORD_W - 1));

  always_comb begin
    raddr_o = addr_full;
    op_o    = op;
    addr_o  = (st == S_DATA) ? addr_sr : addr_full;
    data_o  = data_full;
    fire_o  = cs_i && sclk_rise &&
              ((addr_last && !needs_data && (op != OP_READ)) || data_last);
    sdo_o   = (st == S_READ) && rd_sr[WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      op      <= '0;
      addr_sr <= '0;
      data_sr <= '0;
      rd_sr   <= '0;
    end else if (!cs_i) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (sclk_rise) begin
      unique case (st)
        S_IDLE: if (sdi_i) begin
          st  <= S_OP;
          cnt <= '0;
        end
        S_OP: begin
          op  <= {op[0], sdi_i};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(1)) begin
            st  <= S_ADDR;
            cnt <= '0;
          end
        end
        S_ADDR: begin
          addr_sr <= addr_full;
          cnt     <= cnt + 1'b1;
          if (addr_last) begin
            cnt <= '0;
            if (op == OP_READ) begin
              rd_sr <= {1'b0, rdata_i};
              st    <= S_READ;
            end else if (needs_data) begin
              st <= S_DATA;
            end else begin
              st <= S_DONE;
            end
          end
        end
        S_DATA: begin
          data_sr <= data_full;
          cnt     <= cnt + 1'b1;
          if (data_last) st <= S_DONE;
        end
        S_READ: begin
          rd_sr <= {rd_sr[WORD_W-1:0], 1'b0};
          cnt   <= cnt + 1'b1;
          if (cnt == CW'(WORD_W)) st <= S_DONE;
        end
        default: ;
      endcase
    end
  end

  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |=> (st == S_IDLE));

  p_lead_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_READ) && ($past(st) != S_READ)) |-> !sdo_o);
endmodule

// File: rtl/uwire_store.sv
module uwire_store #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              all_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[i] <= '1;
      else if (we_i && (all_i || (waddr_i == ADDR_W'(i)))) mem[i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];

  p_hold_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> ((raddr_i != $past(raddr_i)) || $stable(rdata_o)));

  p_fill_every_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && all_i) |=> (rdata_o == $past(wdata_i)));
endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
  import uwire_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o
);
  logic              fire;
  logic [1:0]        op;
  logic [ADDR_W-1:0] addr;
  logic [WORD_W-1:0] data;
  logic [ADDR_W-1:0] raddr;
  logic [WORD_W-1:0] rdata;

  logic              wen_q;
  logic              prog_q;
  logic              prog_all_q;
  logic [ADDR_W-1:0] prog_addr_q;
  logic [WORD_W-1:0] prog_data_q;

  uwire_rx #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_i    (cs_i),
    .sclk_i  (sclk_i),
    .sdi_i   (sdi_i),
    .rdata_i (rdata),
    .raddr_o (raddr),
    .fire_o  (fire),
    .op_o    (op),
    .addr_o  (addr),
    .data_o  (data),
    .sdo_o   (sdo_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q       <= 1'b0;
      prog_q      <= 1'b0;
      prog_all_q  <= 1'b0;
      prog_addr_q <= '0;
      prog_data_q <= '0;
    end else begin
      prog_q <= 1'b0;
      if (fire) begin
        prog_addr_q <= addr;
        prog_all_q  <= 1'b0;
        unique case (op)
          OP_WRITE: begin
            prog_q      <= wen_q;
            prog_data_q <= data;
          end
          OP_ERASE: begin
            prog_q      <= wen_q;
            prog_data_q <= '1;
          end
          default: begin
            unique case (addr[ADDR_W-1 -: 2])
              EXT_UNLOCK: wen_q <= 1'b1;
              EXT_LOCK:   wen_q <= 1'b0;
              EXT_CLEAR: begin
                prog_q      <= wen_q;
                prog_all_q  <= 1'b1;
                prog_data_q <= '1;
              end
              default: begin
                prog_q      <= wen_q;
                prog_all_q  <= 1'b1;
                prog_data_q <= data;
              end
            endcase
          end
        endcase
      end
    end
  end

  uwire_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (prog_q),
    .all_i   (prog_all_q),
    .waddr_i (prog_addr_q),
    .wdata_i (prog_data_q),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  p_sdo_low_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |=> !sdo_o);

  p_unlock_needs_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wen_q) |-> $past(cs_i));
endmodule

// File: tb/uwire_eeprom_tb.sv
module uwire_eeprom_tb;
  localparam int AW = 6;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uwire_eeprom #(.ADDR_W(AW), .WORD_W(DW)) u_dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_i   (cs),
    .sclk_i (sclk),
    .sdi_i  (sdi),
    .sdo_o  (sdo)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_on();
    @(negedge clk); cs = 1'b1; sclk = 1'b0; sdi = 1'b0;
    wait_n(2);
  endtask

  task automatic cs_off();
    @(negedge clk); cs = 1'b0; sclk = 1'b0; sdi = 1'b0;
    wait_n(4);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sdi = b; sclk = 1'b0;
    wait_n(4);
    sclk = 1'b1;
    wait_n(4);
  endtask

  task automatic clk_out(output logic b);
    @(negedge clk); sclk = 1'b0;
    wait_n(4);
    sclk = 1'b1;
    wait_n(3);
    b = sdo;
  endtask

  task automatic send_head(input logic [1:0] op, input logic [AW-1:0] a);
    send_bit(1'b1);
    send_bit(op[1]);
    send_bit(op[0]);
    for (int i = AW - 1; i >= 0; i--) send_bit(a[i]);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [AW-1:0] a,
                          input bit with_data, input logic [DW-1:0] d);
    cs_on();
    send_head(op, a);
    if (with_data) for (int i = DW - 1; i >= 0; i--) send_bit(d[i]);
    cs_off();
  endtask

  task automatic unlock(input logic [AW-3:0] low);
    send_cmd(2'b00, {2'b11, low}, 1'b0, '0);
  endtask

  task automatic lock();
    send_cmd(2'b00, {2'b00, {(AW-2){1'b1}}}, 1'b0, '0);
  endtask

  task automatic read_word(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    logic [DW-1:0] v;
    logic b;
    cs_on();
    send_bit(1'b1);
    send_bit(1'b1);
    send_bit(1'b0);
    chk("R9 sdo during command input", {15'd0, sdo}, '0);
    for (int i = AW - 1; i >= 0; i--) send_bit(a[i]);
    chk("R2 leading zero", {15'd0, sdo}, '0);
    for (int i = DW - 1; i >= 0; i--) begin
      clk_out(b);
      v[i] = b;
    end
    chk(req, v, exp);
    clk_out(b);
    chk("R9 sdo after last bit", {15'd0, b}, '0);
    cs_off();
    chk("R9 sdo with select low", {15'd0, sdo}, '0);
  endtask

  task automatic t_reset();
    chk("R1 sdo at reset", {15'd0, sdo}, '0);
    read_word(6'd5, 16'hFFFF, "R1 erased content at reset");
    send_cmd(2'b01, 6'd5, 1'b1, 16'h0000);
    read_word(6'd5, 16'hFFFF, "R1 write before unlock ignored");
  endtask

  task automatic t_write();
    unlock(4'b0101);
    send_cmd(2'b01, 6'd3, 1'b1, 16'hA5C3);
    read_word(6'd3, 16'hA5C3, "R10 R3 write after unlock with odd low bits");
    send_cmd(2'b01, 6'd63, 1'b1, 16'h8001);
    read_word(6'd63, 16'h8001, "R3 R2 write top address msb/lsb");
    read_word(6'd4, 16'hFFFF, "R3 neighbour untouched");
  endtask

  task automatic t_erase();
    send_cmd(2'b11, 6'd3, 1'b0, '0);
    read_word(6'd3, 16'hFFFF, "R4 erase word");
    read_word(6'd63, 16'h8001, "R4 other word kept");
  endtask

  task automatic t_fill();
    send_cmd(2'b00, 6'b01_1010, 1'b1, 16'h1234);
    read_word(6'd0, 16'h1234, "R6 write all word 0");
    read_word(6'd63, 16'h1234, "R6 write all word 63");
  endtask

  task automatic t_clear();
    send_cmd(2'b00, 6'b10_0110, 1'b0, '0);
    read_word(6'd10, 16'hFFFF, "R5 erase all word 10");
    read_word(6'd0, 16'hFFFF, "R5 erase all word 0");
  endtask

  task automatic t_lock();
    send_cmd(2'b01, 6'd7, 1'b1, 16'h0F0F);
    lock();
    send_cmd(2'b01, 6'd7, 1'b1, 16'h0000);
    read_word(6'd7, 16'h0F0F, "R7 write blocked");
    send_cmd(2'b11, 6'd7, 1'b0, '0);
    read_word(6'd7, 16'h0F0F, "R7 erase blocked");
    send_cmd(2'b00, 6'b10_0000, 1'b0, '0);
    read_word(6'd7, 16'h0F0F, "R7 erase all blocked");
    send_cmd(2'b00, 6'b01_0000, 1'b1, 16'h5555);
    read_word(6'd7, 16'h0F0F, "R7 write all blocked");
    unlock(4'b0000);
  endtask

  task automatic t_abort();
    cs_on();
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b0);
    cs_off();
    read_word(6'd9, 16'hFFFF, "R8 aborted fragment no effect");
    cs_on();
    send_bit(1'b0);
    send_bit(1'b0);
    send_bit(1'b0);
    send_head(2'b01, 6'd9);
    for (int i = DW - 1; i >= 0; i--) send_bit(logic'((16'hBEEF >> i) & 1));
    cs_off();
    read_word(6'd9, 16'hBEEF, "R8 zeros before start ignored");
    read_word(6'd7, 16'h0F0F, "R8 other word kept");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    t_reset();
    t_write();
    t_erase();
    t_fill();
    t_clear();
    t_lock();
    t_abort();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule